// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and encodes it as a 32-bit IEEE-754 single-precision word. The working form has a class code, a sign, a signed unbiased exponent, and a significand. The significand holds an explicit leading one, then the fraction, then a guard bit and a round bit. A separate sticky bit collects all lower discarded bits. A 2-bit mode input selects one of four rounding directions. The block then decides the final fraction, the exponent and four exception flags.

Normal results are rounded in place. Results whose biased exponent is zero or below are first denormalised: the leading one is shifted into the fraction field, and every bit that falls off the bottom goes into sticky. Results whose rounded exponent reaches the all-ones code become either infinity or the largest finite magnitude. The choice depends on the rounding direction and the sign. NaN, infinity and zero pass straight to their encodings.

An operand is accepted on a cycle where the input strobe is high. The packed word and all four flags appear together one cycle later, on the output strobe.

Top module: `fp_sgl_pack`

## Requirements
- R1: When `valid_i` is high at a rising edge, `valid_o` is high for exactly one cycle after the second rising edge, and `word_o` and all four flags belong to that operand. At all other times `valid_o` is low.
- R2: Class code 0 (zero) gives `{sign, 31'h0}` with all flags clear.
- R3: Class code 2 (infinity) gives `{sign, 8'hFF, 23'h0}` with all flags clear.
- R4: Class code 3 (NaN) gives `{sign, 8'hFF, mant_i[24:2]}` with all flags clear.
- R5: Class code 1 (number) with biased exponent `exp_i+127` in 1..254, and guard (`mant_i[1]`), round (`mant_i[0]`) and `sticky_i` all zero, gives `{sign, exp_i+127, mant_i[24:2]}` with no flags. `mant_i[25]` is the leading one.
- R6: Mode 0 (nearest) rounds up only when guard is set and round, sticky or the kept LSB is set, so exact halfway cases go to an even result. Any nonzero discarded bit sets `inexact_o`.
- R7: Mode 1 (toward zero) never rounds up. Mode 2 (toward minus infinity) rounds up the magnitude only of inexact negative values. Mode 3 (toward plus infinity) rounds up the magnitude only of inexact positive values.
- R8: When rounding a normal value carries the significand to 2.0, the exponent field rises by one and the fraction field is zero.
- R9: When `exp_i+127 <= 0`, `underflow_o` is set. The significand is shifted right by `1-(exp_i+127)` places before rounding, and the exponent field is 0.
- R10: A denormalised value that rounds up into the implicit-one position gives exponent field 1 and fraction 0. `underflow_o` is still set.
- R11: When the rounded biased exponent is 255 or more, `overflow_o`, `inexact_o` and `operr_o` are all set.
- R12: On overflow the result is infinity in mode 0, and also in mode 3 for positive values and in mode 2 for negative values. In every other case it is `{sign, 8'hFE, 23'h7FFFFF}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| class_i | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign, 1 = negative |
| exp_i | input | IN_EXP_W | Signed unbiased exponent |
| mant_i | input | 26 | Leading one, 23 fraction bits, guard, round |
| sticky_i | input | 1 | OR of all bits below round |
| rnd_mode_i | input | 2 | 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity |
| valid_o | output | 1 | Result strobe |
| word_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Discarded bits were nonzero, or overflow |
| underflow_o | output | 1 | Result took the denormalising path |
| overflow_o | output | 1 | Rounded exponent out of range |
| operr_o | output | 1 | Operand error, raised with overflow |

## Verification
Directed operands are used for three groups of cases:
- Guard, round, sticky and LSB settings that separate a halfway tie from a value just above or below half.
- Each rounding mode paired with both signs, which shows whether the direction logic looks at the sign.
- All-ones significands near the edges of the exponent range. These tell a plain round-up apart from a carry into the exponent, a denormal that becomes the smallest normal, and an overflow to infinity apart from one that saturates.

Denormal shifts of 1, 23, 24, 25 and more than 26 places show whether the guard, round and sticky bits land correctly after the shift. Random operands over an exponent range that covers both the underflow and the overflow limits are compared every cycle against a behavioural reference, which checks the packed word, the flags and the arrival cycle.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int MANT_W  = SIG_W + 2;
  localparam int EXPF_W  = 8;
  localparam int BIAS    = 127;
  localparam int EXP_INF = 255;
  localparam int WORD_W  = 1 + EXPF_W + FRAC_W;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fsp_cls_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_DOWN = 2'd2,
    RND_UP   = 2'd3
  } fsp_rnd_e;
endpackage

// File: rtl/fsp_in_reg.sv
module fsp_in_reg import fsp_pkg::*; #(
  parameter int EXP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              class_i,
  input  logic                    sign_i,
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  input  logic [1:0]              mode_i,
  output logic                    valid_q_o,
  output logic [1:0]              class_q_o,
  output logic                    sign_q_o,
  output logic [EXP_W-1:0]        exp_q_o,
  output logic [MANT_W-1:0]       mant_q_o,
  output logic                    sticky_q_o,
  output logic [1:0]              mode_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q_o  <= 1'b0;
      class_q_o  <= '0;
      sign_q_o   <= 1'b0;
      exp_q_o    <= '0;
      mant_q_o   <= '0;
      sticky_q_o <= 1'b0;
      mode_q_o   <= '0;
    end else begin
      valid_q_o <= valid_i;
      if (valid_i) begin
        class_q_o  <= class_i;
        sign_q_o   <= sign_i;
        exp_q_o    <= exp_i;
        mant_q_o   <= mant_i;
        sticky_q_o <= sticky_i;
        mode_q_o   <= mode_i;
      end
    end
  end
endmodule

// File: rtl/fsp_align.sv
module fsp_align import fsp_pkg::*; #(
  parameter int EXP_W = 10,
  localparam int BE_W = EXP_W + 2
) (
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [MANT_W-1:0]      mant_i,
  input  logic                   sticky_i,
  output logic signed [BE_W-1:0] be_o,
  output logic                   subn_o,
  output logic [SIG_W-1:0]       sig_o,
  output logic                   guard_o,
  output logic                   round_o,
  output logic                   sticky_o
);
  // beyond SH_CAP every bit is already in sticky
  localparam int SH_CAP = MANT_W + 1;
  localparam int SH_W   = $clog2(SH_CAP + 1);
  localparam int EXT_W  = MANT_W + SH_CAP;

  logic signed [BE_W-1:0] sh_full;
  logic [SH_W-1:0]        sh;
  logic [EXT_W-1:0]       ext;
  logic [MANT_W-1:0]      mant_s;

  always_comb begin
    be_o    = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + $signed(BE_W'(BIAS));
    subn_o  = (be_o < $signed(BE_W'(1)));
    sh_full = $signed(BE_W'(1)) - be_o;
    if (!subn_o)                               sh = '0;
    else if (sh_full > $signed(BE_W'(SH_CAP))) sh = SH_W'(SH_CAP);
    else                                       sh = sh_full[SH_W-1:0];
    ext      = {mant_i, {SH_CAP{1'b0}}} >> sh;
    mant_s   = ext[EXT_W-1 -: MANT_W];
    sig_o    = mant_s[MANT_W-1:2];
    guard_o  = mant_s[1];
    round_o  = mant_s[0];
    sticky_o = sticky_i | (|ext[SH_CAP-1:0]);
  end
endmodule

// File: rtl/fsp_round.sv
module fsp_round import fsp_pkg::*; (
  input  logic [1:0]       mode_i,
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  output logic [SIG_W:0]   sum_o,
  output logic             inexact_o
);
  logic up;

  always_comb begin
    inexact_o = guard_i | round_i | sticky_i;
    case (fsp_rnd_e'(mode_i))
      RND_NEAR: up = guard_i & (round_i | sticky_i | sig_i[0]);
      RND_ZERO: up = 1'b0;
      RND_DOWN: up = sign_i & inexact_o;
      default:  up = ~sign_i & inexact_o;
    endcase
    sum_o = {1'b0, sig_i} + {{SIG_W{1'b0}}, up};
  end
endmodule

// File: rtl/fp_sgl_pack.sv
module fp_sgl_pack import fsp_pkg::*; #(
  parameter int IN_EXP_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          class_i,
  input  logic                sign_i,
  input  logic [IN_EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]   mant_i,
  input  logic                sticky_i,
  input  logic [1:0]          rnd_mode_i,
  output logic                valid_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                inexact_o,
  output logic                underflow_o,
  output logic                overflow_o,
  output logic                operr_o
);
  localparam int BE_W = IN_EXP_W + 2;

  logic                   v_q, sgn_q, stk_q;
  logic [1:0]             cls_q, mode_q;
  logic [IN_EXP_W-1:0]    exp_q;
  logic [MANT_W-1:0]      mant_q;

  logic signed [BE_W-1:0] be, exp_r;
  logic                   subn, g, r, s, inx;
  logic [SIG_W-1:0]       sig;
  logic [SIG_W:0]         sum;

  logic [WORD_W-1:0]      w_d;
  logic                   inx_d, unf_d, ovf_d, oper_d, ovf, to_inf;

  fsp_in_reg #(.EXP_W(IN_EXP_W)) u_in (
    .clk_i, .rst_ni, .valid_i, .class_i, .sign_i, .exp_i, .mant_i, .sticky_i,
    .mode_i    (rnd_mode_i),
    .valid_q_o (v_q),
    .class_q_o (cls_q),
    .sign_q_o  (sgn_q),
    .exp_q_o   (exp_q),
    .mant_q_o  (mant_q),
    .sticky_q_o(stk_q),
    .mode_q_o  (mode_q)
  );

  fsp_align #(.EXP_W(IN_EXP_W)) u_align (
    .exp_i   (exp_q),
    .mant_i  (mant_q),
    .sticky_i(stk_q),
    .be_o    (be),
    .subn_o  (subn),
    .sig_o   (sig),
    .guard_o (g),
    .round_o (r),
    .sticky_o(s)
  );

  fsp_round u_round (
    .mode_i   (mode_q),
    .sign_i   (sgn_q),
    .sig_i    (sig),
    .guard_i  (g),
    .round_i  (r),
    .sticky_i (s),
    .sum_o    (sum),
    .inexact_o(inx)
  );

  always_comb begin
    exp_r = be + $signed({{(BE_W-1){1'b0}}, sum[SIG_W]});
    ovf   = ~subn & (exp_r >= $signed(BE_W'(EXP_INF)));
    case (fsp_rnd_e'(mode_q))
      RND_NEAR: to_inf = 1'b1;
      RND_ZERO: to_inf = 1'b0;
      RND_DOWN: to_inf = sgn_q;
      default:  to_inf = ~sgn_q;
    endcase
  end

  always_comb begin
    w_d    = '0;
    inx_d  = 1'b0;
    unf_d  = 1'b0;
    ovf_d  = 1'b0;
    oper_d = 1'b0;
    case (fsp_cls_e'(cls_q))
      CLS_ZERO: w_d = {sgn_q, {(WORD_W-1){1'b0}}};
      CLS_INF:  w_d = {sgn_q, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  w_d = {sgn_q, {EXPF_W{1'b1}}, mant_q[MANT_W-2:2]};
      default: begin
        inx_d = inx;
        if (subn) begin
          unf_d = 1'b1;
          // carry into the implicit-one slot yields exponent field 1
          w_d = {sgn_q, {(EXPF_W-1){1'b0}}, sum[FRAC_W], sum[FRAC_W-1:0]};
        end else if (ovf) begin
          ovf_d  = 1'b1;
          oper_d = 1'b1;
          inx_d  = 1'b1;
          w_d = to_inf ? {sgn_q, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {sgn_q, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
          // a 2.0 significand leaves sum[FRAC_W-1:0] zero
          w_d = {sgn_q, exp_r[EXPF_W-1:0], sum[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      word_o      <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
      operr_o     <= 1'b0;
    end else begin
      valid_o <= v_q;
      if (v_q) begin
        word_o      <= w_d;
        inexact_o   <= inx_d;
        underflow_o <= unf_d;
        overflow_o  <= ovf_d;
        operr_o     <= oper_d;
      end
    end
  end
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk import fsp_pkg::*; #(
  parameter int IN_EXP_W = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [1:0]          class_i,
  input logic                sign_i,
  input logic [IN_EXP_W-1:0] exp_i,
  input logic [MANT_W-1:0]   mant_i,
  input logic                sticky_i,
  input logic [1:0]          rnd_mode_i,
  input logic                valid_o,
  input logic [WORD_W-1:0]   word_o,
  input logic                inexact_o,
  input logic                underflow_o,
  input logic                overflow_o,
  input logic                operr_o
);
  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(class_i, 2) == 2'd0 |->
      word_o[WORD_W-2:0] == '0 && !inexact_o && !overflow_o && !underflow_o);

  p_inf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(class_i, 2) == 2'd2 |->
      word_o[WORD_W-2:0] == 31'h7F80_0000 && !operr_o);

  p_nan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(class_i, 2) == 2'd3 |->
      word_o[WORD_W-2:FRAC_W] == 8'hFF && !inexact_o && !operr_o);

  p_unf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && underflow_o |-> word_o[WORD_W-2:FRAC_W] <= 8'd1);

  p_ovf_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && overflow_o |-> inexact_o && operr_o && !underflow_o);

  p_ovf_tz_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && overflow_o && $past(rnd_mode_i, 2) == 2'd1 |->
      word_o[WORD_W-2:0] == 31'h7F7F_FFFF);

  p_ovf_near_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && overflow_o && $past(rnd_mode_i, 2) == 2'd0 |->
      word_o[WORD_W-2:0] == 31'h7F80_0000);
endmodule

bind fp_sgl_pack fsp_chk #(.IN_EXP_W(IN_EXP_W)) u_chk (.*);

// File: tb/tb_fp_sgl_pack.sv
`timescale 1ns/1ps
module tb_fp_sgl_pack;
  localparam int EW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    class_i = '0;
  logic          sign_i = 1'b0;
  logic [EW-1:0] exp_i = '0;
  logic [25:0]   mant_i = '0;
  logic          sticky_i = 1'b0;
  logic [1:0]    rnd_mode_i = '0;
  logic          valid_o;
  logic [31:0]   word_o;
  logic          inexact_o, underflow_o, overflow_o, operr_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [35:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  fp_sgl_pack #(.IN_EXP_W(EW)) dut (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // {inexact, underflow, overflow, operr, word}
  function automatic logic [35:0] ref_pack(int cls, bit sg, int e, logic [25:0] m,
                                           bit st, int mode);
    longint sig, keep;
    bit stk, g, r, inx, up, unf, toinf;
    int be, ef;
    logic [31:0] sw;
    sw = {sg, 31'h0};
    if (cls == 0) return {4'b0000, sw};
    if (cls == 2) return {4'b0000, sw | 32'h7F80_0000};
    if (cls == 3) return {4'b0000, sw | 32'h7F80_0000 | {9'h0, m[24:2]}};
    be = e + 127;
    sig = longint'(m);
    stk = st;
    unf = 0;
    if (be <= 0) begin
      unf = 1;
      for (int i = 0; i < 1 - be && i < 40; i++) begin
        stk = stk | sig[0];
        sig = sig >> 1;
      end
    end
    g = sig[1];
    r = sig[0];
    keep = sig >> 2;
    inx = g | r | stk;
    case (mode)
      0: up = g && (r || stk || keep[0]);
      1: up = 0;
      2: up = sg && inx;
      default: up = !sg && inx;
    endcase
    keep = keep + (up ? 1 : 0);
    if (unf) begin
      ef = (keep >= 64'h80_0000) ? 1 : 0;
      return {inx, 1'b1, 2'b00, sw | (32'(ef) << 23) | (32'(keep) & 32'h7F_FFFF)};
    end
    ef = be;
    if (keep >= 64'h100_0000) ef = ef + 1;
    if (ef >= 255) begin
      toinf = (mode == 0) || (mode == 3 && !sg) || (mode == 2 && sg);
      return {4'b1011, sw | (toinf ? 32'h7F80_0000 : 32'h7F7F_FFFF)};
    end
    return {inx, 3'b000, sw | (32'(ef) << 23) | (32'(keep) & 32'h7F_FFFF)};
  endfunction

  task automatic send(string tag, int cls, bit sg, int e, logic [25:0] m, bit st, int mode);
    @(negedge clk_i);
    valid_i    = 1'b1;
    class_i    = 2'(cls);
    sign_i     = sg;
    exp_i      = EW'(e);
    mant_i     = m;
    sticky_i   = st;
    rnd_mode_i = 2'(mode);
    exp_q.push_back(ref_pack(cls, sg, e, m, st, mode));
    due_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  // per-cycle comparison against the reference queue (R1 timing included)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected valid_o actual=1 expected=0 at cycle %0d", cyc);
        end else begin
          logic [35:0] ex;
          int          du;
          string       tg;
          ex = exp_q.pop_front();
          du = due_q.pop_front();
          tg = tag_q.pop_front();
          if (du != cyc) begin
            bad++;
            $display("FAIL R1 result cycle actual=%0d expected=%0d", cyc, du);
          end
          if ({inexact_o, underflow_o, overflow_o, operr_o, word_o} !== ex) begin
            bad++;
            $display("FAIL %s actual=%h/%b%b%b%b expected=%h/%b", tg, word_o,
                     inexact_o, underflow_o, overflow_o, operr_o, ex[31:0], ex[35:32]);
          end
        end
      end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
        total++;
        bad++;
        $display("FAIL R1 missing valid_o actual=0 expected=1 at cycle %0d", cyc);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if (valid_o !== 1'b0 || word_o !== 32'h0) begin
      bad++;
      $display("FAIL R1 reset state actual=%b/%h expected=0/00000000", valid_o, word_o);
    end
    rst_ni = 1'b1;
    idle(2);

    send("R2 +zero", 0, 0, 5, 26'h3FF_FFFF, 1, 0);
    send("R2 -zero", 0, 1, 0, 26'h0, 0, 3);
    send("R3 +inf", 2, 0, 0, 26'h0, 0, 1);
    send("R3 -inf", 2, 1, 3, 26'h1234567, 1, 0);
    send("R4 nan", 3, 1, 0, 26'h3A5_A5A4, 0, 0);
    send("R4 nan2", 3, 0, 0, 26'h300_0003, 1, 2);
    send("R5 one", 1, 0, 0, 26'h200_0000, 0, 0);
    send("R5 minnorm", 1, 1, -126, 26'h2AA_AAA8, 0, 1);
    send("R5 maxexp", 1, 0, 127, 26'h2FF_FFFC, 0, 0);
    send("R6 tie even down", 1, 0, 3, 26'h200_0002, 0, 0);
    send("R6 tie odd up", 1, 0, 3, 26'h200_0006, 0, 0);
    send("R6 above half", 1, 0, 3, 26'h200_0003, 0, 0);
    send("R6 sticky half", 1, 1, 3, 26'h200_0002, 1, 0);
    send("R6 below half", 1, 0, 3, 26'h200_0005, 1, 0);
    for (int md = 1; md < 4; md++) begin
      send("R7 mode pos", 1, 0, -5, 26'h245_6781, 0, md);
      send("R7 mode neg", 1, 1, -5, 26'h245_6781, 0, md);
      send("R7 sticky only", 1, 1, 9, 26'h200_0004, 1, md);
    end
    send("R8 carry", 1, 0, 10, 26'h3FF_FFFE, 0, 0);
    send("R8 carry up", 1, 0, -20, 26'h3FF_FFFC, 1, 3);
    send("R9 sub exact", 1, 0, -127, 26'h200_0000, 0, 0);
    send("R9 sub 23", 1, 1, -149, 26'h200_0000, 0, 0);
    send("R9 sub guard", 1, 0, -150, 26'h200_0000, 0, 0);
    send("R9 sub round", 1, 0, -151, 26'h300_0000, 0, 3);
    send("R9 sub far", 1, 0, -200, 26'h3FF_FFFF, 0, 0);
    send("R9 sub far up", 1, 0, -300, 26'h200_0000, 0, 3);
    send("R10 sub to norm", 1, 0, -127, 26'h3FF_FFFF, 0, 0);
    send("R10 sub to norm neg", 1, 1, -127, 26'h3FF_FFFC, 1, 2);
    send("R11 carry ovf", 1, 0, 127, 26'h3FF_FFFE, 0, 0);
    send("R11 big exp", 1, 0, 200, 26'h200_0000, 0, 0);
    send("R12 tz", 1, 0, 128, 26'h200_0000, 0, 1);
    send("R12 up pos", 1, 0, 130, 26'h211_1111, 0, 3);
    send("R12 up neg", 1, 1, 130, 26'h211_1111, 0, 3);
    send("R12 down neg", 1, 1, 130, 26'h211_1111, 0, 2);
    send("R12 down pos", 1, 0, 130, 26'h211_1111, 0, 2);
    idle(1);
    send("R1 gap", 1, 0, 1, 26'h255_5555, 0, 0);
    idle(3);

    for (int k = 0; k < 600; k++) begin
      int cls;
      cls = ($urandom_range(9) == 0) ? int'($urandom_range(3)) : 1;
      send("R6 R7 R9 R11 random", cls, 1'($urandom_range(1)),
           int'($urandom_range(310)) - 165,
           {1'b1, 25'($urandom)}, 1'($urandom_range(1)), int'($urandom_range(3)));
      if ($urandom_range(4) == 0) idle(1);
    end
    idle(6);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 pending results actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule